// File: doc/BRIEF.md
# Edge-triggered interrupt message controller

The block watches eleven interrupt input lines, records their current levels and captures every low-to-high transition in a pending register. Each source has a mask bit and a route bit. When a rising edge arrives on a masked-in source, the block issues one outbound 32-bit write. The route bit picks one of two target registers. The message address is that target with its five low bits cleared, and the message data is those five low bits.

Software reaches the block through a word-wide register port with separate read and write strobes and a 12-bit byte offset. Reads are combinational in the strobe cycle. Reading the pending register returns its contents and clears it, and a write to the pending register also clears it. Two read-only request views report, for each route, the sources that are high, masked in and steered that way.

Outbound messages wait in a per-source bitmap behind a single output register. The bus may stall for any length of time without a message being lost. Waiting sources leave in ascending source order, one per accepted handshake.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset, msg_valid is 0. Both target registers (offsets 0x004 and 0x010) read CPU_BASE+3. The mask (0x018), route (0x024), pending (0x01C) and level (0x028) registers read 0. An offset with no register reads 0.
- R2: The level register at 0x028 shows the input vector, in bits 0..10, one clock edge after the inputs change.
- R3: A pending bit is set only by a rising edge, that is an input at 1 whose level bit is 0. An input held high does not set its pending bit again after it has been cleared.
- R4: A read of 0x01C returns the pending bits and clears them at that clock edge. A write to 0x01C clears them whatever the data. An edge that arrives in the clearing cycle is kept.
- R5: The mask and route registers store write-data bits 0..10 and read back 0 above bit 10. Both target registers store and return all 32 bits.
- R6: View 0 at 0x00C reads level AND mask AND NOT route. View 1 at 0x014 reads level AND mask AND route.
- R7: Writes to 0x00C, 0x014 and 0x028 change no register.
- R8: A masked-in edge whose route bit is 0 produces a message built from target 0 (0x004). Route bit 1 selects target 1 (0x010). The message has msg_addr = target AND 0xFFFFFFE0 and msg_data = target AND 0x1F. The route bit is taken at the edge. The target value is taken when the message enters the output register. msg_valid rises after the second clock edge that follows the input rising.
- R9: An edge on a source whose mask bit is 0 produces no message.
- R10: While msg_valid is 1 and msg_ready is 0, the message stays unchanged. Sources that are waiting are issued in ascending source order, one per handshake, and a new message follows a handshake with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 11 | Interrupt input levels, already synchronous to clk |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| msg_valid | output | 1 | Outbound write request valid |
| msg_ready | input | 1 | Outbound write request accepted |
| msg_addr | output | 32 | Outbound write address |
| msg_data | output | 32 | Outbound write data |

## Verification
An input change becomes visible in the level and pending registers after one clock edge. The message it raises appears after the second edge, and each handshake brings up the next waiting message after one further edge. The bench drives every input on a falling edge and samples on a falling edge. It counts falling edges from the stimulus to the cycle in which each result is due, and also checks that msg_valid is still low one cycle earlier. Register reads are sampled within the strobe cycle. The clearing effect of a read is observed with a second read in a later cycle.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
   localparam int OFF_W = 12;
   localparam logic [OFF_W-1:0] OFF_TGT0  = 12'h004;
   localparam logic [OFF_W-1:0] OFF_VIEW0 = 12'h00C;
   localparam logic [OFF_W-1:0] OFF_TGT1  = 12'h010;
   localparam logic [OFF_W-1:0] OFF_VIEW1 = 12'h014;
   localparam logic [OFF_W-1:0] OFF_MASK  = 12'h018;
   localparam logic [OFF_W-1:0] OFF_PEND  = 12'h01C;
   localparam logic [OFF_W-1:0] OFF_ROUTE = 12'h024;
   localparam logic [OFF_W-1:0] OFF_LEVEL = 12'h028;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
   parameter int NSRC = 11
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src_i,
   input  logic            clr_i,
   output logic [NSRC-1:0] lvl_o,
   output logic [NSRC-1:0] pend_o,
   output logic [NSRC-1:0] edge_o
);
   logic [NSRC-1:0] lvl_q, pend_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      // rising edge: input high while the recorded level is still low
      assign edge_o[i] = src_i[i] & ~lvl_q[i];
      always_ff @(posedge clk) begin
         if (rst) begin
            lvl_q[i]  <= 1'b0;
            pend_q[i] <= 1'b0;
         end else begin
            lvl_q[i]  <= src_i[i];
            pend_q[i] <= (clr_i ? 1'b0 : pend_q[i]) | edge_o[i];
         end
      end
   end

   assign lvl_o  = lvl_q;
   assign pend_o = pend_q;

   // R3: a newly set pending bit always matches a newly risen level bit
   assert_pend_on_rise_R3 : assert property (@(posedge clk) disable iff (rst)
      ((pend_q & ~$past(pend_q)) & ~(lvl_q & ~$past(lvl_q))) == '0);

   // R4: a clear with no edge present leaves the register empty
   assert_clear_empties_R4 : assert property (@(posedge clk) disable iff (rst)
      (clr_i && ((src_i & ~lvl_q) == '0)) |=> (pend_q == '0));
endmodule

// File: rtl/irq_msg_queue.sv
module irq_msg_queue #(
   parameter int NSRC  = 11,
   parameter int DW    = 32,
   parameter int ALIGN = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] new_i,
   input  logic [NSRC-1:0] route_i,
   input  logic [DW-1:0]   tgt0_i,
   input  logic [DW-1:0]   tgt1_i,
   input  logic            ready_i,
   output logic            valid_o,
   output logic [DW-1:0]   addr_o,
   output logic [DW-1:0]   data_o
);
   localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

   logic [NSRC-1:0] bm_q, rt_q, pick_1h;
   logic [IW-1:0]   pick_idx, src_q;
   logic            any, load, v_q;
   logic [DW-1:0]   tgt_q;

   // lowest waiting source wins
   always_comb begin
      pick_idx = '0;
      pick_1h  = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (bm_q[i]) begin
            pick_idx = IW'(i);
            pick_1h  = NSRC'(1) << i;
         end
      end
   end

   assign any  = |bm_q;
   assign load = any && (!v_q || ready_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         bm_q  <= '0;
         rt_q  <= '0;
         v_q   <= 1'b0;
         src_q <= '0;
         tgt_q <= '0;
      end else begin
         bm_q <= (bm_q & ~(load ? pick_1h : '0)) | new_i;
         for (int i = 0; i < NSRC; i++)
            if (new_i[i]) rt_q[i] <= route_i[i];
         if (load) begin
            v_q   <= 1'b1;
            src_q <= pick_idx;
            tgt_q <= rt_q[pick_idx] ? tgt1_i : tgt0_i;
         end else if (ready_i) begin
            v_q <= 1'b0;
         end
      end
   end

   assign valid_o = v_q;
   assign addr_o  = {tgt_q[DW-1:ALIGN], {ALIGN{1'b0}}};
   assign data_o  = {{(DW-ALIGN){1'b0}}, tgt_q[ALIGN-1:0]};

   // R10: a stalled message holds still
   assert_stall_hold_R10 : assert property (@(posedge clk) disable iff (rst)
      (v_q && !ready_i) |=> (v_q && $stable(addr_o) && $stable(data_o)));

   // R10: a waiting source follows a handshake without a gap
   assert_back_to_back_R10 : assert property (@(posedge clk) disable iff (rst)
      (v_q && ready_i && any) |=> v_q);

   // R8: an issued message names a real source
   assert_src_range_R8 : assert property (@(posedge clk) disable iff (rst)
      v_q |-> (int'(src_q) < NSRC));
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl #(
   parameter int          NSRC     = 11,
   parameter int          DW       = 32,
   parameter int          ALIGN    = 5,
   parameter logic [31:0] CPU_BASE = 32'hFFFE_0000
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [10:0] src_in,
   input  logic        reg_rd,
   input  logic        reg_wr,
   input  logic [11:0] reg_off,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        msg_valid,
   input  logic        msg_ready,
   output logic [31:0] msg_addr,
   output logic [31:0] msg_data
);
   import irq_msg_pkg::*;

   localparam logic [DW-1:0] TGT_RST = DW'(CPU_BASE + 32'd3);

   if (NSRC != 11 || DW != 32) begin : g_bad_width
      $error("port widths are fixed at 11 sources and 32 data bits");
   end
   if (ALIGN < 1 || ALIGN >= DW) begin : g_bad_align
      $error("ALIGN must lie within the data word");
   end

   logic [NSRC-1:0] mask_q, route_q, lvl, pend, edge_v;
   logic [DW-1:0]   tgt0_q, tgt1_q;
   logic            pend_clr;

   assign pend_clr = (reg_rd || reg_wr) && (reg_off == OFF_PEND);

   irq_edge_capture #(.NSRC(NSRC)) u_cap (
      .clk(clk), .rst(rst), .src_i(src_in), .clr_i(pend_clr),
      .lvl_o(lvl), .pend_o(pend), .edge_o(edge_v)
   );

   irq_msg_queue #(.NSRC(NSRC), .DW(DW), .ALIGN(ALIGN)) u_q (
      .clk(clk), .rst(rst), .new_i(edge_v & mask_q), .route_i(route_q),
      .tgt0_i(tgt0_q), .tgt1_i(tgt1_q), .ready_i(msg_ready),
      .valid_o(msg_valid), .addr_o(msg_addr), .data_o(msg_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q  <= '0;
         route_q <= '0;
         tgt0_q  <= TGT_RST;
         tgt1_q  <= TGT_RST;
      end else if (reg_wr) begin
         unique case (reg_off)
            OFF_MASK:  mask_q  <= reg_wdata[NSRC-1:0];
            OFF_ROUTE: route_q <= reg_wdata[NSRC-1:0];
            OFF_TGT0:  tgt0_q  <= reg_wdata;
            OFF_TGT1:  tgt1_q  <= reg_wdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (reg_off)
            OFF_TGT0:  reg_rdata = tgt0_q;
            OFF_TGT1:  reg_rdata = tgt1_q;
            OFF_MASK:  reg_rdata = DW'(mask_q);
            OFF_ROUTE: reg_rdata = DW'(route_q);
            OFF_PEND:  reg_rdata = DW'(pend);
            OFF_LEVEL: reg_rdata = DW'(lvl);
            OFF_VIEW0: reg_rdata = DW'(lvl & mask_q & ~route_q);
            OFF_VIEW1: reg_rdata = DW'(lvl & mask_q & route_q);
            default:   reg_rdata = '0;
         endcase
      end
   end

   // R9: no message starts unless a masked-in edge was seen earlier
   assert_masked_only_R9 : assert property (@(posedge clk) disable iff (rst)
      ($rose(msg_valid) && ($past(mask_q) == '0) && ($past(mask_q, 2) == '0)
       && ($past(msg_valid, 2) == 1'b0)) |-> 1'b0);
endmodule

// File: tb/irq_msg_ctrl_tb.sv
module irq_msg_ctrl_tb;
   logic        clk = 0, rst = 1;
   logic [10:0] src_in = '0;
   logic        reg_rd = 0, reg_wr = 0, msg_ready = 1;
   logic [11:0] reg_off = '0;
   logic [31:0] reg_wdata = '0, reg_rdata, msg_addr, msg_data;
   logic        msg_valid;
   int          n_chk = 0, n_bad = 0;

   irq_msg_ctrl u_dut (
      .clk(clk), .rst(rst), .src_in(src_in), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
      .msg_data(msg_data)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd(input logic [11:0] off, output logic [31:0] v);
      reg_rd = 1; reg_off = off; #1 v = reg_rdata;
      tick(); reg_rd = 0;
   endtask

   task automatic wr(input logic [11:0] off, input logic [31:0] v);
      reg_wr = 1; reg_off = off; reg_wdata = v;
      tick(); reg_wr = 0;
   endtask

   task automatic expect_rd(input string req, input logic [11:0] off, input logic [31:0] e);
      logic [31:0] v;
      rd(off, v);
      chk(req, v, e);
   endtask

   task automatic t_reset;
      chk("R1 valid", {31'd0, msg_valid}, 0);
      expect_rd("R1 tgt0", 12'h004, 32'hFFFE_0003);
      expect_rd("R1 tgt1", 12'h010, 32'hFFFE_0003);
      expect_rd("R1 mask", 12'h018, 0);
      expect_rd("R1 route", 12'h024, 0);
      expect_rd("R1 pend", 12'h01C, 0);
      expect_rd("R1 level", 12'h028, 0);
      expect_rd("R1 hole", 12'h100, 0);
   endtask

   task automatic t_level;
      src_in = 11'h401; tick();
      expect_rd("R2 level set", 12'h028, 32'h401);
      src_in = 11'h000; tick();
      expect_rd("R2 level clear", 12'h028, 0);
      wr(12'h01C, 0);
   endtask

   task automatic t_rw;
      wr(12'h018, 32'hFFFF_FFFF);
      expect_rd("R5 mask", 12'h018, 32'h7FF);
      wr(12'h024, 32'h0000_F0F0);
      expect_rd("R5 route", 12'h024, 32'h0F0);
      wr(12'h004, 32'h1234_5678);
      expect_rd("R5 tgt0", 12'h004, 32'h1234_5678);
      wr(12'h010, 32'hCAFE_F00D);
      expect_rd("R5 tgt1", 12'h010, 32'hCAFE_F00D);
   endtask

   task automatic t_views;
      wr(12'h018, 32'h0FF);
      wr(12'h024, 32'h0F0);
      src_in = 11'h3C3; tick(3);
      expect_rd("R6 view0", 12'h00C, 32'h003);
      expect_rd("R6 view1", 12'h014, 32'h0C0);
      wr(12'h00C, 32'hFFFF_FFFF);
      wr(12'h014, 32'hFFFF_FFFF);
      wr(12'h028, 32'h0);
      expect_rd("R7 level kept", 12'h028, 32'h3C3);
      expect_rd("R7 mask kept", 12'h018, 32'h0FF);
      expect_rd("R7 view0 kept", 12'h00C, 32'h003);
      src_in = '0; wr(12'h018, 0); tick(4);
      wr(12'h01C, 0);
   endtask

   task automatic t_pending;
      logic [31:0] v;
      src_in = 11'h004; tick();
      expect_rd("R3 edge sets", 12'h01C, 32'h004);
      expect_rd("R4 read cleared", 12'h01C, 0);
      tick(3);
      expect_rd("R3 held high no reset", 12'h01C, 0);
      src_in = '0; tick();
      src_in = 11'h024; tick();
      wr(12'h01C, 32'h0);
      expect_rd("R4 write clears", 12'h01C, 0);
      // edge arriving in the clearing cycle survives
      src_in = 11'h02C; reg_rd = 1; reg_off = 12'h01C; #1 v = reg_rdata;
      tick(); reg_rd = 0;
      chk("R4 read value", v, 0);
      expect_rd("R4 edge kept", 12'h01C, 32'h008);
      src_in = '0; tick(); wr(12'h01C, 0);
   endtask

   task automatic t_msg;
      wr(12'h004, 32'h8000_0025);
      wr(12'h010, 32'h9000_004A);
      wr(12'h018, 32'h401);
      wr(12'h024, 32'h400);
      src_in = 11'h002;
      tick(); chk("R9 c1", {31'd0, msg_valid}, 0);
      tick(); chk("R9 c2", {31'd0, msg_valid}, 0);
      tick(); chk("R9 c3", {31'd0, msg_valid}, 0);
      src_in = 11'h402;
      tick(); chk("R8 not early", {31'd0, msg_valid}, 0);
      tick(); chk("R8 valid t1", {31'd0, msg_valid}, 1);
      chk("R8 addr t1", msg_addr, 32'h9000_0040);
      chk("R8 data t1", msg_data, 32'h0000_000A);
      tick(); chk("R8 one message", {31'd0, msg_valid}, 0);
      src_in = 11'h403;
      tick(2); chk("R8 valid t0", {31'd0, msg_valid}, 1);
      chk("R8 addr t0", msg_addr, 32'h8000_0020);
      chk("R8 data t0", msg_data, 32'h0000_0005);
      src_in = '0; tick(2); wr(12'h01C, 0);
   endtask

   task automatic t_stall;
      wr(12'h018, 32'h7FF);
      wr(12'h024, 32'h120);
      msg_ready = 0;
      src_in = 11'h124;
      tick(2);
      chk("R10 first valid", {31'd0, msg_valid}, 1);
      chk("R10 first addr", msg_addr, 32'h8000_0020);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R10 stall valid", {31'd0, msg_valid}, 1);
         chk("R10 stall addr", msg_addr, 32'h8000_0020);
         chk("R10 stall data", msg_data, 32'h5);
      end
      msg_ready = 1;
      tick(); chk("R10 second addr", msg_addr, 32'h9000_0040);
      chk("R10 second valid", {31'd0, msg_valid}, 1);
      tick(); chk("R10 third addr", msg_addr, 32'h9000_0040);
      chk("R10 third valid", {31'd0, msg_valid}, 1);
      tick(); chk("R10 drained", {31'd0, msg_valid}, 0);
      src_in = '0; tick(); wr(12'h01C, 0);
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      tick(3); rst = 0; tick();
      t_reset();
      t_level();
      t_rw();
      t_views();
      t_pending();
      t_msg();
      t_stall();
      finish_run();
   end
endmodule